// File: doc/BRIEF.md
# Fast-Lock Delay Line Lock Controller

This controller brings a digital delay-locked loop into lock in two phases. First it takes one time-to-digital measurement of the loop delay: it fires a single start pulse into the loop model and, on the following clock edge, captures the pattern that the returning edge has left in a measure delay array. The captured pattern is a thermometer code. The controller converts it into a stage count. From that count and a configured clock period, expressed in delay stages, it computes how many forward delay stages are needed to pad the loop out to a whole number of clock periods. It then loads that count in one step.

When the coarse count is loaded, the controller moves the output multiplexer off the bypass path and onto the forward delay array. From then on it tracks slowly. Each early or late decision from the phase detector moves a fine interpolation code by one step. The fine code carries into the coarse count when it overflows and borrows from it when it underflows. After every coarse change the phase detector is ignored for a few cycles while the delay line settles. Lock is declared once the fine code has reversed direction a set number of times in a row.

Top module: `mcd_lock_ctrl`

## Requirements
- R1: After reset release, `start_o` is high for exactly one cycle, in the cycle after the first clock edge. It is never high while `fwd_sel_o` is high. During reset, every output is 0.
- R2: `therm_i` is captured on the clock edge that ends the start pulse. The measured count is the number of consecutive ones counted upward from bit 0 until the first zero. Ones above a zero (a bubble) are not counted.
- R3: With measured count m and period P = `period_i`, the loaded coarse value is N·P − m, where N is the smallest integer of at least 1 that makes the result non-negative. m = 0 gives P, and P = 0 gives 0.
- R4: On the third clock edge after reset release, the controller loads the coarse value, drives `fwd_sel_o` to 1 and sets `fine_o` to its midpoint 2^(FINE_W−1).
- R5: The phase-detector inputs have no effect for SETTLE_CYC clock edges after the load and after every coarse change.
- R6: While tracking, early-only (`pd_early_i`=1, `pd_late_i`=0) adds one to `fine_o` and late-only subtracts one. Both high or both low leaves `fine_o` unchanged.
- R7: An early step from the all-ones fine code wraps it to 0 and adds one to `coarse_o`. A late step from 0 wraps it to all-ones and subtracts one from `coarse_o`. At coarse 0 (for a borrow) or FWD_STAGES−1 (for a carry) such a step is dropped and nothing changes.
- R8: `lock_o` rises on the step that completes LOCK_FLIPS consecutive direction reversals. A step in the same direction as the previous one restarts the count. Once high, `lock_o` stays high until reset.
- R9: Once `fwd_sel_o` is 1 it stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | MEAS_STAGES | Thermometer snapshot from the measure delay array |
| period_i | input | CW | Clock period expressed in forward delay stages |
| pd_early_i | input | 1 | Phase detector: output edge early, delay should grow |
| pd_late_i | input | 1 | Phase detector: output edge late, delay should shrink |
| start_o | output | 1 | Start pulse launched into the loop model |
| fwd_sel_o | output | 1 | Output mux select: 0 bypass, 1 forward array |
| coarse_o | output | CW | Forward delay array stage select |
| fine_o | output | FINE_W | Fine interpolation code |
| lock_o | output | 1 | Lock achieved |

## Verification
A fine-code wrap and the completion of lock can land on the same clock edge. When that happens, one step both changes `coarse_o` and counts as the final direction reversal. The bench provokes this case by pushing the fine code over its top and then alternating early and late at the boundary, so that every step is itself a carry or a borrow. It checks that `lock_o` rises on the same edge as the last borrow, with the coarse and fine values the requirements predict. A behavioural model, built from integers, follows every edge through the settle windows and flags any cycle where a pending reversal is lost or a carry is skipped.

// File: rtl/mcd_lock_pkg.sv
`timescale 1ns/1ps
package mcd_lock_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_LAUNCH, ST_LOAD, ST_SETTLE, ST_TRACK
  } ctl_state_e;

  typedef enum logic [1:0] {
    DIR_NONE, DIR_UP, DIR_DN
  } move_dir_e;
endpackage

// File: rtl/mcd_therm_count.sv
`timescale 1ns/1ps
module mcd_therm_count #(
  parameter int STAGES = 16,
  parameter int CNT_W  = $clog2(STAGES + 1)
) (
  input  logic [STAGES-1:0] therm_i,
  output logic [CNT_W-1:0]  count_o
);
  // ones from bit 0 up to the first zero; anything above a bubble is dropped
  always_comb begin
    logic             run;
    logic [CNT_W-1:0] cnt;
    run = 1'b1;
    cnt = '0;
    for (int i = 0; i < STAGES; i++) begin
      if (run && therm_i[i]) cnt = cnt + CNT_W'(1);
      else                   run = 1'b0;
    end
    count_o = cnt;
  end
endmodule

// File: rtl/mcd_coarse_calc.sv
`timescale 1ns/1ps
module mcd_coarse_calc #(
  parameter int MEAS_W = 5,
  parameter int CW     = 5,
  parameter int ITER   = 16
) (
  input  logic [MEAS_W-1:0] meas_i,
  input  logic [CW-1:0]     period_i,
  output logic [CW-1:0]     coarse_o
);
  localparam int XW = (MEAS_W > CW) ? MEAS_W : CW;

  // remainder by repeated subtraction, bounded by the measure depth
  always_comb begin
    logic [XW-1:0] rem;
    logic [XW-1:0] per;
    rem = XW'(meas_i);
    per = XW'(period_i);
    for (int i = 0; i < ITER; i++) begin
      if (per != '0 && rem >= per) rem = rem - per;
    end
    if (per == '0)                       coarse_o = '0;
    else if (rem == '0 && meas_i != '0)  coarse_o = '0;
    else                                 coarse_o = CW'(per - rem);
  end
endmodule

// File: rtl/mcd_fine_track.sv
`timescale 1ns/1ps
module mcd_fine_track
  import mcd_lock_pkg::*;
#(
  parameter int FINE_W     = 3,
  parameter int LOCK_FLIPS = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              track_i,
  input  logic              early_i,
  input  logic              late_i,
  input  logic              at_top_i,
  input  logic              at_zero_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              carry_o,
  output logic              borrow_o,
  output logic              lock_o
);
  localparam int                FL_W = $clog2(LOCK_FLIPS + 1);
  localparam logic [FINE_W-1:0] FMAX = '1;
  localparam logic [FINE_W-1:0] FMID = FINE_W'(1) << (FINE_W - 1);
  localparam logic [FL_W-1:0]   FLIM = FL_W'(LOCK_FLIPS);

  logic [FINE_W-1:0] fine_q;
  logic [FL_W-1:0]   flips_q;
  move_dir_e         dir_q, new_dir;
  logic              lock_q, go_up, go_dn, step, rev;

  always_comb begin
    go_up    = track_i & early_i & ~late_i & ~((fine_q == FMAX) & at_top_i);
    go_dn    = track_i & late_i & ~early_i & ~((fine_q == '0) & at_zero_i);
    carry_o  = go_up & (fine_q == FMAX);
    borrow_o = go_dn & (fine_q == '0);
    step     = go_up | go_dn;
    new_dir  = go_up ? DIR_UP : DIR_DN;
    rev      = step && (dir_q != DIR_NONE) && (dir_q != new_dir);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fine_q  <= '0;
      dir_q   <= DIR_NONE;
      flips_q <= '0;
      lock_q  <= 1'b0;
    end else begin
      if (load_i)     fine_q <= FMID;
      else if (go_up) fine_q <= fine_q + FINE_W'(1);
      else if (go_dn) fine_q <= fine_q - FINE_W'(1);
      if (step) begin
        dir_q <= new_dir;
        if (rev) begin
          if (flips_q != FLIM) flips_q <= flips_q + FL_W'(1);
          if (flips_q >= FLIM - FL_W'(1)) lock_q <= 1'b1;
        end else begin
          flips_q <= '0;
        end
      end
    end
  end

  assign fine_o = fine_q;
  assign lock_o = lock_q;
endmodule

// File: rtl/mcd_lock_ctrl.sv
`timescale 1ns/1ps
module mcd_lock_ctrl
  import mcd_lock_pkg::*;
#(
  parameter int  MEAS_STAGES = 16,
  parameter int  FWD_STAGES  = 32,
  parameter int  FINE_W      = 3,
  parameter int  SETTLE_CYC  = 4,
  parameter int  LOCK_FLIPS  = 3,
  localparam int CW          = $clog2(FWD_STAGES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [MEAS_STAGES-1:0] therm_i,
  input  logic [CW-1:0]          period_i,
  input  logic                   pd_early_i,
  input  logic                   pd_late_i,
  output logic                   start_o,
  output logic                   fwd_sel_o,
  output logic [CW-1:0]          coarse_o,
  output logic [FINE_W-1:0]      fine_o,
  output logic                   lock_o
);
  localparam int            MEAS_W = $clog2(MEAS_STAGES + 1);
  localparam int            SW     = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SLOAD  = SW'(SETTLE_CYC);
  localparam logic [CW-1:0] CTOP   = CW'(FWD_STAGES - 1);

  ctl_state_e             state_q;
  logic [MEAS_STAGES-1:0] snap_q;
  logic [CW-1:0]          coarse_q, coarse_calc;
  logic [SW-1:0]          settle_q;
  logic [MEAS_W-1:0]      meas_cnt;
  logic                   start_q, sel_q, carry, borrow;

  mcd_therm_count #(.STAGES(MEAS_STAGES), .CNT_W(MEAS_W)) u_count (
    .therm_i (snap_q),
    .count_o (meas_cnt)
  );

  mcd_coarse_calc #(.MEAS_W(MEAS_W), .CW(CW), .ITER(MEAS_STAGES)) u_calc (
    .meas_i   (meas_cnt),
    .period_i (period_i),
    .coarse_o (coarse_calc)
  );

  mcd_fine_track #(.FINE_W(FINE_W), .LOCK_FLIPS(LOCK_FLIPS)) u_fine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (state_q == ST_LOAD),
    .track_i   (state_q == ST_TRACK),
    .early_i   (pd_early_i),
    .late_i    (pd_late_i),
    .at_top_i  (coarse_q == CTOP),
    .at_zero_i (coarse_q == '0),
    .fine_o    (fine_o),
    .carry_o   (carry),
    .borrow_o  (borrow),
    .lock_o    (lock_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      snap_q   <= '0;
      coarse_q <= '0;
      settle_q <= '0;
      start_q  <= 1'b0;
      sel_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          start_q <= 1'b1;
          state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          snap_q  <= therm_i;   // stop edge has landed in the measure array
          start_q <= 1'b0;
          state_q <= ST_LOAD;
        end
        ST_LOAD: begin
          coarse_q <= coarse_calc;
          sel_q    <= 1'b1;
          settle_q <= SLOAD;
          state_q  <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_q <= SW'(1)) state_q <= ST_TRACK;
          else                    settle_q <= settle_q - SW'(1);
        end
        ST_TRACK: begin
          if (carry || borrow) begin
            coarse_q <= carry ? coarse_q + CW'(1) : coarse_q - CW'(1);
            settle_q <= SLOAD;
            state_q  <= ST_SETTLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign start_o   = start_q;
  assign fwd_sel_o = sel_q;
  assign coarse_o  = coarse_q;
endmodule

// File: rtl/mcd_lock_chk.sv
`timescale 1ns/1ps
module mcd_lock_chk #(
  parameter int FINE_W     = 3,
  parameter int CW         = 5,
  parameter int SETTLE_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_o,
  input logic              fwd_sel_o,
  input logic [CW-1:0]     coarse_o,
  input logic [FINE_W-1:0] fine_o,
  input logic              lock_o
);
  localparam int                HW   = $clog2(SETTLE_CYC + 1);
  localparam logic [FINE_W-1:0] FMAX = '1;

  logic          prev_sel_q;
  logic [CW-1:0] prev_coarse_q;
  logic [HW-1:0] hold_q;
  logic          trig;

  assign trig = fwd_sel_o && (!prev_sel_q || coarse_o != prev_coarse_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_sel_q    <= 1'b0;
      prev_coarse_q <= '0;
      hold_q        <= '0;
    end else begin
      prev_sel_q    <= fwd_sel_o;
      prev_coarse_q <= coarse_o;
      if (trig)              hold_q <= HW'(SETTLE_CYC);
      else if (hold_q != '0) hold_q <= hold_q - HW'(1);
    end
  end

  assert_start_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  assert_start_bypass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> !fwd_sel_o);

  assert_settle_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_q != '0) |-> $stable(fine_o));

  assert_fine_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_o && $past(fwd_sel_o) && coarse_o == $past(coarse_o)) |->
      (fine_o == $past(fine_o) || fine_o == FINE_W'($past(fine_o) + 1'b1) ||
       fine_o == FINE_W'($past(fine_o) - 1'b1)));

  assert_coarse_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_sel_o && $past(fwd_sel_o) && coarse_o != $past(coarse_o)) |->
      ((coarse_o == CW'($past(coarse_o) + 1'b1) && fine_o == '0 && $past(fine_o) == FMAX) ||
       (coarse_o == CW'($past(coarse_o) - 1'b1) && fine_o == FMAX && $past(fine_o) == '0)));

  assert_lock_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  assert_sel_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_sel_o |=> fwd_sel_o);
endmodule

bind mcd_lock_ctrl mcd_lock_chk #(
  .FINE_W(FINE_W), .CW(CW), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_o   (start_o),
  .fwd_sel_o (fwd_sel_o),
  .coarse_o  (coarse_o),
  .fine_o    (fine_o),
  .lock_o    (lock_o)
);

// File: tb/sim_mcd_lock_ctrl.sv
`timescale 1ns/1ps
module sim_mcd_lock_ctrl;
  localparam int MS = 16, FS = 32, FW = 3, ST = 4, LF = 3;
  localparam int CW = $clog2(FS);
  localparam int FMAX = (1 << FW) - 1;
  localparam int FMID = 1 << (FW - 1);

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [MS-1:0] therm = '0;
  logic [CW-1:0] period = '0;
  logic          early = 1'b0, late = 1'b0;
  logic          start_w, sel_w, lock_w;
  logic [CW-1:0] coarse_w;
  logic [FW-1:0] fine_w;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mcd_lock_ctrl #(.MEAS_STAGES(MS), .FWD_STAGES(FS), .FINE_W(FW),
                  .SETTLE_CYC(ST), .LOCK_FLIPS(LF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .therm_i(therm), .period_i(period),
    .pd_early_i(early), .pd_late_i(late), .start_o(start_w),
    .fwd_sel_o(sel_w), .coarse_o(coarse_w), .fine_o(fine_w), .lock_o(lock_w));

  // behavioural reference model
  int m_ph, m_start, m_sel, m_coarse, m_fine, m_lock, m_hold, m_dir, m_flips;
  logic [MS-1:0] m_snap;

  function automatic int ones_run(logic [MS-1:0] t);
    int k = 0;
    while (k < MS && t[k]) k++;
    return k;
  endfunction

  function automatic int coarse_of(int m, int p);
    if (p == 0) return 0;
    if (m == 0) return p;
    return (m % p == 0) ? 0 : p - (m % p);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_start = 0; m_sel = 0; m_coarse = 0; m_fine = 0;
      m_lock = 0; m_hold = 0; m_dir = 0; m_flips = 0; m_snap = '0;
    end else begin
      case (m_ph)
        0: begin m_start = 1; m_ph = 1; end
        1: begin m_snap = therm; m_start = 0; m_ph = 2; end
        2: begin
          m_coarse = coarse_of(ones_run(m_snap), int'(period));
          m_sel = 1; m_fine = FMID; m_hold = ST; m_ph = 3;
        end
        3: begin m_hold--; if (m_hold == 0) m_ph = 4; end
        default: begin
          int d = 0;
          if (early && !late) begin
            if (m_fine < FMAX) begin m_fine++; d = 1; end
            else if (m_coarse < FS - 1) begin
              m_fine = 0; m_coarse++; m_hold = ST; m_ph = 3; d = 1;
            end
          end else if (late && !early) begin
            if (m_fine > 0) begin m_fine--; d = 2; end
            else if (m_coarse > 0) begin
              m_fine = FMAX; m_coarse--; m_hold = ST; m_ph = 3; d = 2;
            end
          end
          if (d != 0) begin
            if (m_dir != 0 && m_dir != d) begin
              m_flips++;
              if (m_flips >= LF) m_lock = 1;
            end else m_flips = 0;
            m_dir = d;
          end
        end
      endcase
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // cycle compare against model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R1 start", int'(start_w), m_start);
      chk("R9 sel", int'(sel_w), m_sel);
      chk("R3 coarse", int'(coarse_w), m_coarse);
      chk("R6 fine", int'(fine_w), m_fine);
      chk("R8 lock", int'(lock_w), m_lock);
    end
  end

  task automatic boot(logic [MS-1:0] t, int p);
    rst_n = 1'b0;
    therm = t; period = CW'(p);
    repeat (2) @(negedge clk);
    chk("R1 reset start", int'(start_w), 0);
    chk("R1 reset sel", int'(sel_w), 0);
    chk("R1 reset lock", int'(lock_w), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pulse high", int'(start_w), 1);
    @(negedge clk);
    chk("R1 pulse low", int'(start_w), 0);
    therm = ~t;  // must not disturb the captured snapshot (R2)
    @(negedge clk);
  endtask

  task automatic pd(logic e, logic l, int n);
    early = e; late = l;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // A: m=6, P=10; carry, borrow and lock on the same edge as a borrow
    early = 1'b1; late = 1'b0;
    boot(16'h003F, 10);
    chk("R3 coarse m6 p10", int'(coarse_w), 4);
    chk("R4 sel loaded", int'(sel_w), 1);
    chk("R4 fine mid", int'(fine_w), FMID);
    pd(1'b1, 1'b0, ST);
    chk("R5 settle ignores early", int'(fine_w), FMID);
    pd(1'b1, 1'b0, 1);
    chk("R6 early step", int'(fine_w), FMID + 1);
    pd(1'b1, 1'b0, 3);
    chk("R7 carry fine", int'(fine_w), 0);
    chk("R7 carry coarse", int'(coarse_w), 5);
    pd(1'b0, 1'b1, ST + 1);
    chk("R7 borrow fine", int'(fine_w), FMAX);
    chk("R7 borrow coarse", int'(coarse_w), 4);
    pd(1'b1, 1'b0, ST + 1);
    chk("R8 not yet locked", int'(lock_w), 0);
    pd(1'b0, 1'b1, ST + 1);
    chk("R8 lock with borrow", int'(lock_w), 1);
    chk("R7 collision coarse", int'(coarse_w), 4);
    pd(1'b1, 1'b1, ST + 6);
    chk("R6 both hold", int'(fine_w), FMAX);
    pd(1'b0, 1'b0, 4);
    chk("R6 neither hold", int'(fine_w), FMAX);
    chk("R8 lock sticky", int'(lock_w), 1);

    // B..E: measurement conversions
    early = 1'b0; late = 1'b0;
    boot(16'h0000, 10);
    chk("R3 zero count gives P", int'(coarse_w), 10);
    boot(16'h0FFF, 5);
    chk("R3 N=3", int'(coarse_w), 3);
    boot(16'h03EF, 10);
    chk("R2 bubble stops count", int'(coarse_w), 6);
    boot(16'hFFFF, 7);
    chk("R3 full array", int'(coarse_w), 5);
    boot(16'hFFFF, 16);
    chk("R3 exact multiple", int'(coarse_w), 0);

    // F: P=0 and borrow at coarse zero dropped
    boot(16'h0007, 0);
    chk("R3 P zero", int'(coarse_w), 0);
    pd(1'b0, 1'b1, ST + 10);
    chk("R7 borrow dropped fine", int'(fine_w), 0);
    chk("R7 borrow dropped coarse", int'(coarse_w), 0);
    chk("R8 one direction no lock", int'(lock_w), 0);

    // G: carry at the top coarse stage dropped
    boot(16'h0000, FS - 1);
    pd(1'b1, 1'b0, ST + 10);
    chk("R7 carry dropped fine", int'(fine_w), FMAX);
    chk("R7 carry dropped coarse", int'(coarse_w), FS - 1);

    // H: plain alternation locks on the third reversal
    boot(16'h003F, 10);
    pd(1'b0, 1'b0, ST);
    pd(1'b1, 1'b0, 1); pd(1'b0, 1'b1, 1); pd(1'b1, 1'b0, 1);
    chk("R8 two reversals", int'(lock_w), 0);
    pd(1'b0, 1'b1, 1);
    chk("R8 third reversal locks", int'(lock_w), 1);

    // I: a repeated direction restarts the reversal count
    boot(16'h003F, 10);
    pd(1'b0, 1'b0, ST);
    pd(1'b1, 1'b0, 1); pd(1'b0, 1'b1, 1); pd(1'b1, 1'b0, 2);
    pd(1'b0, 1'b1, 1); pd(1'b1, 1'b0, 1);
    chk("R8 restart no lock", int'(lock_w), 0);
    chk("R9 sel held", int'(sel_w), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule